// File: doc/BRIEF.md
# Three-Lane Balanced Serial Transmitter

This block turns a stream of 21-bit parallel words into three serial data lanes plus a fourth lane that carries a frame-rate clock pattern. It runs from a single bit-rate clock. A frame is one parallel word. A frame lasts 7 bit periods in raw mode and 9 bit periods in balanced mode. Lane k carries input bits 7k to 7k+6, and the least significant bit is sent first.

In balanced mode, each data lane keeps its own running disparity. Count +1 for every one sent and -1 for every zero sent. For each new word, the lane checks whether the 7 payload bits would push that sum further from zero. If they would, the lane sends them inverted. After the payload it appends an inversion flag and then the flag's complement. In this mode the clock lane alternates between 4 high bits and 5 high bits in successive frames, so its own sum stays balanced.

Words enter over a valid/ready stream. `in_ready` is high for exactly one cycle per frame: the last bit period of the current frame, or the single load cycle that starts the first frame after reset. A word is taken when `in_valid` and `in_ready` are both high in the same cycle. A source that is not ready holds its word and waits for the next `in_ready`; the block never stalls the serial output. If `in_valid` is low in the load cycle, the next frame carries an all-zero payload. In balanced mode that payload is still coded. The mode input is sampled in the same load cycle. A mode change therefore starts with the next frame.

Top module: `tx3_serializer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lane_bit`, `clk_lane`, `frame_start` and `in_ready` are all 0. The first load cycle is the second cycle after release.
- R2: Lane k sends input bits 7k..7k+6, starting with bit 7k. Its first bit appears in the cycle after the load cycle.
- R3: In raw mode (`bal_mode`=0) a frame is 7 bits of unmodified payload. The clock lane is high for the first 4 bits and low for the last 3.
- R4: In balanced mode (`bal_mode`=1) a frame is 9 bits: the 7 payload bits (inverted when the flag is 1), then the flag, then its complement.
- R5: For each lane, the flag is 1 only when the lane's running disparity and the payload's disparity (2*ones-7) are both nonzero and have the same sign. Raw frames leave the running disparity unchanged.
- R6: Summed over balanced frames only, the ones-minus-zeros count sent on each data lane stays within ±7 at every frame start.
- R7: In balanced mode the clock lane is high for the first 4 bits and first 5 bits of successive balanced frames. The first balanced frame after reset uses 4. The alternation toggles only at the end of a balanced frame.
- R8: `bal_mode` is sampled only in the load cycle. Changing it in mid-frame alters neither the current frame's length nor its content.
- R9: `frame_start` is high for one cycle, on the first bit of every frame.
- R10: `in_ready` is high only in the load cycle. A word is accepted when `in_valid` is also high. Otherwise the next frame's payload is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bal_mode | input | 1 | 1 selects balanced 9-bit frames, 0 selects raw 7-bit frames |
| in_valid | input | 1 | Parallel word is valid |
| in_ready | output | 1 | Block takes a word this cycle (load cycle) |
| in_word | input | 21 | Parallel payload word |
| lane_bit | output | 3 | Serial bit of each data lane |
| clk_lane | output | 1 | Serial frame clock pattern |
| frame_start | output | 1 | Marks the first bit of each frame |

## Verification
The embedded assertions assume only that `rst_n` is synchronous and that the inputs are stable around the rising edge. They place no constraints on the stream side. Valid may drop in any cycle, the word may change freely, and the mode may toggle at any bit. The bench therefore drives all three at random on the falling edge, with no protocol restriction. It also includes directed runs that stress disparity: all-ones and all-zero words, starved input, and bursts of mode toggling in mid-frame.

// File: rtl/tx3_pkg.sv
package tx3_pkg;
  // running disparity of one lane; holds at least +/- (payload width)
  typedef logic signed [5:0] disp_t;
  // coding bits appended to a balanced frame: flag, then its complement
  localparam int CODE_W = 2;
  typedef enum logic {MODE_RAW = 1'b0, MODE_BAL = 1'b1} mode_e;
endpackage

// File: rtl/tx3_framer.sv
module tx3_framer
  import tx3_pkg::*;
#(
  parameter int PAY_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_in,
  output logic load,
  output logic cur_bal,
  output logic clk_bit,
  output logic frame_start
);
  localparam int FRAME_W = PAY_BITS + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_RAW = CNT_W'(PAY_BITS);
  localparam logic [CNT_W-1:0] LEN_BAL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] HI_SHORT = CNT_W'((PAY_BITS + 1) / 2);
  localparam logic [CNT_W-1:0] HI_LONG  = CNT_W'((FRAME_W + 1) / 2);

  logic             started;
  logic             run;
  logic             phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] flen;
  logic             last;

  always_comb begin
    flen = cur_bal ? LEN_BAL : LEN_RAW;
    last = run && (cnt == flen - 1'b1);
    load = started && (!run || last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      run     <= 1'b0;
      cnt     <= '0;
      cur_bal <= MODE_BAL;
      phase   <= 1'b0;
    end else begin
      started <= 1'b1;
      if (load) begin
        run     <= 1'b1;
        cnt     <= '0;
        cur_bal <= mode_in;
        if (run && cur_bal) phase <= ~phase;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    clk_bit     = run && (cnt < ((cur_bal && phase) ? HI_LONG : HI_SHORT));
    frame_start = run && (cnt == '0);
  end

  // a raw frame never reaches the coding-bit positions
  p_raw_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cur_bal) |-> (cnt < LEN_RAW));

  // every frame start is preceded by a load cycle
  p_start_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(load));

  // the clock lane is high on the first bit of every frame
  p_clk_high_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> clk_bit);
endmodule

// File: rtl/tx3_lane.sv
module tx3_lane
  import tx3_pkg::*;
#(
  parameter int PAY_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                bal_next,
  input  logic [PAY_BITS-1:0] data,
  output logic                ser_bit
);
  localparam int FRAME_W = PAY_BITS + CODE_W;

  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] frame_next;
  disp_t              rs;
  disp_t              rs_next;
  disp_t              word_disp;
  logic               inv;

  always_comb begin
    word_disp = disp_t'(2 * $countones(data) - PAY_BITS);
    inv = bal_next &&
          (((rs > 0) && (word_disp > 0)) || ((rs < 0) && (word_disp < 0)));
    if (bal_next) begin
      frame_next = {~inv, inv, data ^ {PAY_BITS{inv}}};
      rs_next    = inv ? (rs - word_disp) : (rs + word_disp);
    end else begin
      frame_next = {{CODE_W{1'b0}}, data};
      rs_next    = rs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      rs <= '0;
    end else if (load) begin
      sh <= frame_next;
      rs <= rs_next;
    end else begin
      sh <= sh >> 1;
    end
  end

  assign ser_bit = sh[0];

  // the word-boundary disparity of a lane never leaves +/- payload width
  p_disp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs <= disp_t'(PAY_BITS)) && (rs >= -disp_t'(PAY_BITS)));
endmodule

// File: rtl/tx3_serializer.sv
module tx3_serializer
  import tx3_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int PAY_BITS = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bal_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*PAY_BITS-1:0] in_word,
  output logic [LANES-1:0]          lane_bit,
  output logic                      clk_lane,
  output logic                      frame_start
);
  logic load;
  logic cur_bal;

  tx3_framer #(.PAY_BITS(PAY_BITS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_in    (bal_mode),
    .load       (load),
    .cur_bal    (cur_bal),
    .clk_bit    (clk_lane),
    .frame_start(frame_start)
  );

  assign in_ready = load;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PAY_BITS-1:0] slice;
    assign slice = in_valid ? in_word[k*PAY_BITS +: PAY_BITS] : '0;
    tx3_lane #(.PAY_BITS(PAY_BITS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .bal_next(bal_mode),
      .data    (slice),
      .ser_bit (lane_bit[k])
    );
  end

  // a load cycle is always followed by a frame start
  p_ready_then_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> frame_start);

  // ready and frame start never coincide except at a one-bit frame (never)
  p_ready_not_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready);
endmodule

// File: tb/tx3_serializer_test.sv
`timescale 1ns/1ps
module tx3_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bal_mode = 1'b1;
  logic        in_valid = 1'b0;
  logic [20:0] in_word = '0;
  logic        in_ready;
  logic [2:0]  lane_bit;
  logic        clk_lane;
  logic        frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx3_serializer uut (
    .clk(clk), .rst_n(rst_n), .bal_mode(bal_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .lane_bit(lane_bit),
    .clk_lane(clk_lane), .frame_start(frame_start)
  );

  // reference state
  bit       m_started, m_run, m_bal, m_phase;
  int       m_cnt;
  int       m_rs [3];
  bit [8:0] m_sh [3];
  int       sum_out [3];
  int       cyc, last_start, prev_len;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_clk();
    return (m_run && m_cnt < ((m_bal && m_phase) ? 5 : 4)) ? 1 : 0;
  endfunction

  function automatic int exp_ready();
    return (m_started && (!m_run || m_cnt == (m_bal ? 9 : 7) - 1)) ? 1 : 0;
  endfunction

  task automatic model_step(input bit ld, input bit v, input bit [20:0] w, input bit md);
    if (ld) begin
      for (int k = 0; k < 3; k++) begin
        bit [6:0] d;
        int ones, dd;
        bit inv;
        d = v ? w[7*k +: 7] : 7'd0;
        ones = $countones(d);
        dd = 2 * ones - 7;
        inv = md && ((m_rs[k] > 0 && dd > 0) || (m_rs[k] < 0 && dd < 0));
        if (md) begin
          m_sh[k] = {~inv, inv, d ^ {7{inv}}};
          m_rs[k] = inv ? m_rs[k] - dd : m_rs[k] + dd;
        end else begin
          m_sh[k] = {2'b00, d};
        end
      end
      if (m_run && m_bal) m_phase = ~m_phase;
      m_bal = md;
      m_run = 1;
      m_cnt = 0;
    end else if (m_run) begin
      m_cnt++;
      for (int k = 0; k < 3; k++) m_sh[k] = m_sh[k] >> 1;
    end
    m_started = 1;
  endtask

  initial begin
    #(5.0 * 60000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_started = 0; m_run = 0; m_bal = 1; m_phase = 0; m_cnt = 0;
    last_start = -1; prev_len = 0;
    for (int k = 0; k < 3; k++) begin m_rs[k] = 0; m_sh[k] = '0; sum_out[k] = 0; end

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 lane_bit", lane_bit, 0);
      chk("R1 clk_lane", clk_lane, 0);
      chk("R1 frame_start", frame_start, 0);
      chk("R1 in_ready", in_ready, 0);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 4200; i++) begin
      int ph;
      bit ld;
      string tl, tc;
      cyc = i;
      if (i > 0) @(negedge clk);
      // compare outputs against the reference state
      tl = m_bal ? "R2 R4 R5 lane" : "R2 R3 lane";
      tc = m_bal ? "R7 clk" : "R3 clk";
      for (int k = 0; k < 3; k++) chk(tl, lane_bit[k], m_sh[k][0]);
      chk(tc, clk_lane, exp_clk());
      chk("R9 frame_start", frame_start, (m_run && m_cnt == 0) ? 1 : 0);
      ld = exp_ready() != 0;
      chk(i == 0 ? "R1 in_ready" : "R10 in_ready", in_ready, ld ? 1 : 0);
      if (frame_start) begin
        // R8: frame length fixed by the mode sampled at its load cycle
        if (last_start >= 0) chk("R8 frame length", i - last_start, prev_len);
        last_start = i;
        prev_len = m_bal ? 9 : 7;
        // R6: balance of actually transmitted bits
        for (int k = 0; k < 3; k++)
          chk("R6 disparity", (sum_out[k] <= 7 && sum_out[k] >= -7) ? 1 : 0, 1);
      end
      if (m_run && m_bal)
        for (int k = 0; k < 3; k++) sum_out[k] += lane_bit[k] ? 1 : -1;

      // choose stimulus
      ph = i / 600;
      in_valid = ($urandom % 4) != 0;
      in_word  = 21'($urandom);
      case (ph)
        0: bal_mode = 1'b1;
        1: bal_mode = 1'b0;
        2: begin bal_mode = 1'b1; in_word = '1; end
        3: begin bal_mode = 1'b1; in_word = '0; in_valid = ($urandom % 3) == 0; end
        4: if (($urandom % 5) == 0) bal_mode = ~bal_mode;  // R8 mid-frame toggles
        5: begin bal_mode = 1'b1; in_word = 21'h155555; end
        default: if (($urandom % 11) == 0) bal_mode = ~bal_mode;
      endcase
      model_step(ld, in_valid, in_word, bal_mode);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule